// File: doc/BRIEF.md
# Discrete PI Current Controller With Anti-Windup

This block closes a current loop in fixed point. Whenever a sample strobe arrives, it subtracts the measured current from the commanded current. It folds that error into a running integral using the trapezoidal rule, adding the present error and the one from the previous sample. It then emits a control word built from a proportional term and an integral term. The control word is rounded and scaled down by a programmable number of fractional bits. It is then limited to a pair of programmable bounds, which stand for full positive duty and full negative duty of the modulator that follows.

The integral has its own symmetric bound, set apart from the output limits. When the output is pinned at a limit, this bound keeps the accumulated sum from growing without end, so the loop recovers quickly once the error changes sign. Gains, shift and limits are static configuration inputs. A one-cycle valid pulse marks each new control word, and the word holds its value between updates.

Top module: `pi_current_ctrl`

## Requirements
- R1: On each clock where `smp_stb` is 1, the error e = `iref_in` − `imeas_in` is formed at full precision (one bit wider than the inputs). In cycles without a strobe, the current inputs change neither the controller state nor the output.
- R2: For each strobe, the integral is updated as s(k) = s(k−1) + e(k) + e(k−1). After reset, both s and the previous error are 0, so the first update after reset uses e(k−1) = 0.
- R3: Let acc = `kp_gain`·e(k) + `ki_gain`·s(k), where the gains are unsigned and e and s are signed. The control word is acc rounded and arithmetically shifted right by `frac_shift`, then limited.
- R4: Rounding adds 2^(`frac_shift`−1) before the arithmetic right shift, which rounds half toward +infinity. With `frac_shift` = 0, no rounding term is added.
- R5: A scaled value above `out_hi_lim` (signed) yields exactly `out_hi_lim`.
- R6: A scaled value below `out_lo_lim` (signed) yields exactly `out_lo_lim`.
- R7: After each update, the integral is clamped into [−`sum_lim`, +`sum_lim`] (`sum_lim` unsigned). This clamp is independent of the output limits, and the clamped value is the one stored and used.
- R8: `ctl_vld` is 1 for exactly one clock. It rises at the third rising edge that counts the edge sampling the strobe, and `ctl_out` carries the new word in that same cycle. Strobes on consecutive clocks each produce their own result in order.
- R9: Synchronous active-high `rst` clears `ctl_out` to 0, `ctl_vld` to 0, the integral, the previous error and all in-flight samples.
- R10: While `ctl_vld` is 0, `ctl_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one update per high cycle |
| iref_in | input | 16 | Commanded current, signed |
| imeas_in | input | 16 | Measured current, signed |
| kp_gain | input | 16 | Proportional gain, unsigned |
| ki_gain | input | 16 | Integral gain, unsigned |
| frac_shift | input | 5 | Fractional bits removed from the product sum |
| sum_lim | input | 23 | Magnitude bound of the integral, unsigned |
| out_hi_lim | input | 16 | Upper output limit (full positive duty), signed |
| out_lo_lim | input | 16 | Lower output limit (full negative duty), signed |
| ctl_out | output | 16 | Control word, signed |
| ctl_vld | output | 1 | One-cycle pulse marking a new control word |

## Verification
Each control word is due three rising edges after the strobe is driven: the sampling edge, the integrator edge and the output edge. The bench's behavioural model computes the word when the strobe is issued and files it with that due cycle. On every clock, the bench samples shortly after the edge and demands that `ctl_vld` be high exactly in due cycles. It compares `ctl_out` with the queued value there and requires the previous value in all other cycles. Configuration changes wait until the pipeline has drained, so every queued value was computed with the settings the design used.

// File: rtl/pi_ctl_pkg.sv
package pi_ctl_pkg;

    parameter int DATA_W  = 16;
    parameter int GAIN_W  = 16;
    parameter int SUM_W   = 24;
    parameter int OUT_W   = 16;
    parameter int SHIFT_W = 5;

    localparam int ERR_W = DATA_W + 1;
    localparam int RAW_W = SUM_W + 2;
    localparam int ACC_W = GAIN_W + SUM_W + 2;
    localparam int LIM_W = SUM_W - 1;

    typedef logic signed [DATA_W-1:0]  cur_t;
    typedef logic signed [ERR_W-1:0]   err_t;
    typedef logic signed [SUM_W-1:0]   sum_t;
    typedef logic signed [RAW_W-1:0]   raw_t;
    typedef logic signed [ACC_W-1:0]   acc_t;
    typedef logic signed [OUT_W-1:0]   out_t;
    typedef logic        [GAIN_W-1:0]  gain_t;
    typedef logic        [LIM_W-1:0]   lim_t;
    typedef logic        [SHIFT_W-1:0] shamt_t;

    typedef struct packed {
        logic vld;
        err_t err;
    } stage_t;

    function automatic sum_t clamp_sum(raw_t raw, lim_t lim);
        raw_t pos;
        raw_t neg;
        pos = raw_t'(lim);
        neg = -pos;
        if (raw > pos)
            return sum_t'(pos);
        else if (raw < neg)
            return sum_t'(neg);
        else
            return sum_t'(raw);
    endfunction

    function automatic acc_t round_shift(acc_t a, shamt_t sh);
        acc_t half;
        half = (sh == '0) ? '0 : (acc_t'(1) <<< (sh - 1'b1));
        return (a + half) >>> sh;
    endfunction

    function automatic out_t sat_out(acc_t a, out_t lo, out_t hi);
        if (a > acc_t'(hi))
            return hi;
        else if (a < acc_t'(lo))
            return lo;
        else
            return out_t'(a);
    endfunction

endpackage

// File: rtl/pi_err_stage.sv
module pi_err_stage
    import pi_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stb,
    input  cur_t   iref,
    input  cur_t   imeas,
    output stage_t s1
);

    err_t err_now;

    always_comb begin
        err_now = err_t'(iref) - err_t'(imeas);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= stb;
            if (stb)
                s1.err <= err_now;
        end
    end

endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
    import pi_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t s1,
    input  lim_t   lim,
    output stage_t s2,
    output sum_t   sum_q
);

    err_t prev_err;
    raw_t raw_sum;
    sum_t sum_nxt;

    always_comb begin
        raw_sum = raw_t'(sum_q) + raw_t'(s1.err) + raw_t'(prev_err);
        sum_nxt = clamp_sum(raw_sum, lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2       <= '0;
            prev_err <= '0;
            sum_q    <= '0;
        end else begin
            s2.vld <= s1.vld;
            if (s1.vld) begin
                s2.err   <= s1.err;
                prev_err <= s1.err;
                sum_q    <= sum_nxt;
            end
        end
    end

endmodule

// File: rtl/pi_out_stage.sv
module pi_out_stage
    import pi_ctl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  stage_t s2,
    input  sum_t   sum_q,
    input  gain_t  kp,
    input  gain_t  ki,
    input  shamt_t sh,
    input  out_t   lo,
    input  out_t   hi,
    output out_t   word,
    output logic   vld
);

    acc_t p_term;
    acc_t i_term;
    acc_t scaled;
    out_t limited;

    always_comb begin
        p_term  = acc_t'(kp) * acc_t'(s2.err);
        i_term  = acc_t'(ki) * acc_t'(sum_q);
        scaled  = round_shift(p_term + i_term, sh);
        limited = sat_out(scaled, lo, hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= s2.vld;
            if (s2.vld)
                word <= limited;
        end
    end

endmodule

// File: rtl/pi_current_ctrl.sv
module pi_current_ctrl
    import pi_ctl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_stb,
    input  logic signed [DATA_W-1:0]  iref_in,
    input  logic signed [DATA_W-1:0]  imeas_in,
    input  logic        [GAIN_W-1:0]  kp_gain,
    input  logic        [GAIN_W-1:0]  ki_gain,
    input  logic        [SHIFT_W-1:0] frac_shift,
    input  logic        [LIM_W-1:0]   sum_lim,
    input  logic signed [OUT_W-1:0]   out_hi_lim,
    input  logic signed [OUT_W-1:0]   out_lo_lim,
    output logic signed [OUT_W-1:0]   ctl_out,
    output logic                      ctl_vld
);

    stage_t s1;
    stage_t s2;
    sum_t   integ_sum;
    logic   sum_upd;

    assign sum_upd = s2.vld;

    pi_err_stage u_err (
        .clk   (clk),
        .rst   (rst),
        .stb   (smp_stb),
        .iref  (iref_in),
        .imeas (imeas_in),
        .s1    (s1)
    );

    pi_integrator u_int (
        .clk   (clk),
        .rst   (rst),
        .s1    (s1),
        .lim   (sum_lim),
        .s2    (s2),
        .sum_q (integ_sum)
    );

    pi_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .s2    (s2),
        .sum_q (integ_sum),
        .kp    (kp_gain),
        .ki    (ki_gain),
        .sh    (frac_shift),
        .lo    (out_lo_lim),
        .hi    (out_hi_lim),
        .word  (ctl_out),
        .vld   (ctl_vld)
    );

endmodule

// File: rtl/pi_current_ctrl_chk.sv
module pi_current_ctrl_chk
    import pi_ctl_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     smp_stb,
    input logic signed [OUT_W-1:0]  ctl_out,
    input logic                     ctl_vld,
    input logic signed [OUT_W-1:0]  out_hi_lim,
    input logic signed [OUT_W-1:0]  out_lo_lim,
    input logic        [LIM_W-1:0]  sum_lim,
    input logic signed [SUM_W-1:0]  integ_sum,
    input logic                     sum_upd
);

    logic [2:0] stb_hist;
    logic signed [SUM_W:0] lim_pos;
    logic signed [SUM_W:0] lim_neg;

    always_ff @(posedge clk) begin
        if (rst)
            stb_hist <= '0;
        else
            stb_hist <= {stb_hist[1:0], smp_stb};
    end

    assign lim_pos = $signed({2'b00, sum_lim});
    assign lim_neg = -lim_pos;

    // R8
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_vld == stb_hist[2]);

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_vld |-> $stable(ctl_out));

    // R5
    upper_limit_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_vld |-> ctl_out <= out_hi_lim);

    // R6
    lower_limit_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_vld |-> ctl_out >= out_lo_lim);

    // R7
    integ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sum_upd |-> (integ_sum <= lim_pos && integ_sum >= lim_neg));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (ctl_out == '0 && !ctl_vld));

endmodule

bind pi_current_ctrl pi_current_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .ctl_out    (ctl_out),
    .ctl_vld    (ctl_vld),
    .out_hi_lim (out_hi_lim),
    .out_lo_lim (out_lo_lim),
    .sum_lim    (sum_lim),
    .integ_sum  (integ_sum),
    .sum_upd    (sum_upd)
);

// File: tb/pi_current_ctrl_tb_top.sv
module pi_current_ctrl_tb_top;
    import pi_ctl_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_stb = 1'b0;
    logic signed [DATA_W-1:0] iref_in = '0;
    logic signed [DATA_W-1:0] imeas_in = '0;
    logic [GAIN_W-1:0] kp_gain = '0;
    logic [GAIN_W-1:0] ki_gain = '0;
    logic [SHIFT_W-1:0] frac_shift = '0;
    logic [LIM_W-1:0] sum_lim = '0;
    logic signed [OUT_W-1:0] out_hi_lim = '0;
    logic signed [OUT_W-1:0] out_lo_lim = '0;
    logic signed [OUT_W-1:0] ctl_out;
    logic ctl_vld;

    always #4 clk = ~clk;

    pi_current_ctrl dut_i (.*);

    int    cyc = 0;
    int    n_checks = 0;
    int    n_errors = 0;
    string phase = "R9";
    bit    done = 1'b0;

    longint m_sum = 0;
    longint m_prev = 0;
    longint last_out = 0;
    longint exp_q[$];
    int     due_q[$];

    task automatic check(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // per-clock comparison, sampled 2 ns after the rising edge
    always begin
        @(posedge clk);
        cyc++;
        #2;
        if (!rst && !done) begin
            bit due;
            due = (due_q.size() > 0) && (due_q[0] == cyc);
            check({phase, "/R8 valid"}, longint'(ctl_vld), longint'(due));
            if (due) begin
                check({phase, "/R3 word"}, longint'(ctl_out), exp_q[0]);
                last_out = exp_q[0];
                void'(exp_q.pop_front());
                void'(due_q.pop_front());
            end else begin
                check({phase, "/R10 hold"}, longint'(ctl_out), last_out);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_errors++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            summary();
        end
    end

    function automatic longint model_step(longint r, longint m);
        longint e;
        longint raw;
        longint lim;
        longint acc;
        e   = r - m;
        raw = m_sum + e + m_prev;
        lim = longint'(sum_lim);
        if (raw > lim) raw = lim;
        if (raw < -lim) raw = -lim;
        m_sum  = raw;
        m_prev = e;
        acc = longint'(kp_gain) * e + longint'(ki_gain) * m_sum;
        if (frac_shift != 0) acc = acc + (64'sd1 <<< (frac_shift - 1));
        acc = acc >>> frac_shift;
        if (acc > longint'(out_hi_lim)) acc = longint'(out_hi_lim);
        if (acc < longint'(out_lo_lim)) acc = longint'(out_lo_lim);
        return acc;
    endfunction

    task automatic send(int r, int m);
        @(negedge clk);
        iref_in  = DATA_W'(r);
        imeas_in = DATA_W'(m);
        smp_stb  = 1'b1;
        exp_q.push_back(model_step(longint'(r), longint'(m)));
        due_q.push_back(cyc + 3);
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            iref_in  = DATA_W'($urandom);
            imeas_in = DATA_W'($urandom);
        end
    endtask

    task automatic cfg(int kp, int ki, int sh, int lim, int lo, int hi);
        idle(5);
        kp_gain    = GAIN_W'(kp);
        ki_gain    = GAIN_W'(ki);
        frac_shift = SHIFT_W'(sh);
        sum_lim    = LIM_W'(lim);
        out_lo_lim = OUT_W'(lo);
        out_hi_lim = OUT_W'(hi);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_stb = 1'b0;
        exp_q.delete();
        due_q.delete();
        m_sum = 0;
        m_prev = 0;
        last_out = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        cfg(1, 0, 0, 1000, -30000, 30000);
        do_reset();
        @(negedge clk);
        @(negedge clk);
        // R9: reset state at the ports
        check("R9 reset out", longint'(ctl_out), 0);
        check("R9 reset vld", longint'(ctl_vld), 0);

        // R1: error is reference minus measurement; idle inputs ignored
        phase = "R1";
        send(500, 200);
        idle(6);
        send(-100, 400);
        idle(6);
        send(-32768, 32767);
        idle(6);

        // R2: trapezoidal sum, first update after reset uses zero previous error
        phase = "R2";
        cfg(0, 1, 0, 100000, -30000, 30000);
        do_reset();
        send(10, 0);
        idle(4);
        send(20, 0);
        idle(4);
        send(-5, 0);
        idle(4);

        // R4: rounding half up before arithmetic shift
        phase = "R4";
        cfg(3, 0, 2, 100000, -30000, 30000);
        send(5, 0);
        send(-5, 0);
        send(2, 0);
        send(-2, 0);
        idle(4);

        // R5 / R6: output saturation at both limits
        phase = "R5";
        cfg(100, 0, 0, 100000, -1500, 2000);
        send(50, 0);
        send(20, 0);
        idle(4);
        phase = "R6";
        send(-50, 0);
        send(-15, 0);
        idle(4);

        // R7: integral clamp independent of output saturation
        phase = "R7";
        cfg(0, 1, 0, 100, -30000, 30000);
        do_reset();
        for (int i = 0; i < 10; i++) send(30, 0);
        send(0, 30);
        send(0, 30);
        send(0, 30);
        idle(4);
        cfg(0, 50, 0, 100, -1000, 1000);
        for (int i = 0; i < 6; i++) send(40, 0);
        send(0, 40);
        idle(4);

        // R8: back-to-back strobes each give their own result
        phase = "R8";
        cfg(2, 1, 1, 5000, -20000, 20000);
        for (int i = 0; i < 6; i++) send(100 * i - 250, 17);
        idle(4);

        // R3: mixed gains and shifts over varied stimulus
        phase = "R3";
        cfg(1200, 40, 6, 200000, -16000, 16000);
        for (int i = 0; i < 150; i++) begin
            int r;
            int m;
            r = int'($urandom_range(0, 8000)) - 4000;
            m = int'($urandom_range(0, 8000)) - 4000;
            send(r, m);
            idle(int'($urandom_range(0, 2)));
        end
        idle(4);

        // R9: reset mid-run clears integral and previous error
        phase = "R9";
        cfg(0, 1, 0, 100000, -30000, 30000);
        send(300, 0);
        send(300, 0);
        do_reset();
        send(7, 0);
        idle(6);

        done = 1'b1;
        summary();
    end

endmodule